// File: doc/BRIEF.md
# Round-Robin Event Destination Selector

This block picks the destination that each outgoing event is sent to. A table of sixteen 4-bit destination IDs is held in two 32-bit configuration words. A third 32-bit word sets the run length, which is the number of events that go to one destination before the selection moves on. Each pulse on the event-done strobe counts one event. When the run length is reached, the table pointer steps to the next entry and wraps from the last entry back to the first.

A run length of zero turns rotation off. In that case the first table entry is the fixed destination. A new run length is latched only at a switch point, so a run that has already started always finishes with the length it began with. The destination ID and the slot index are both registered outputs.

Top module: `evt_dest_rotator`

## Requirements
- R1: A synchronous active-high reset sets the slot to 0 and the event counter to 0. One clock edge after reset is released, dest_id equals tbl_lo[3:0].
- R2: Table entry k is bits [4k+3:4k] of the 64-bit value {tbl_hi, tbl_lo}. Entry 0 is tbl_lo[3:0], entry 7 is tbl_lo[31:28], entry 8 is tbl_hi[3:0] and entry 15 is tbl_hi[31:28].
- R3: With a latched run length N > 0, exactly N events are counted on a slot. The N-th event moves the selection to the next slot.
- R4: Slots are visited in ascending order, and slot 15 is followed by slot 0.
- R5: While the latched run length is 0, the slot is 0 and events do not move it. A run that ends when the configured run length is 0 returns the slot to 0.
- R6: A change of run_len during a run does not alter that run. The new value is latched at the next switch point, and counting restarts from zero there. While in the zero-length state, a nonzero run_len is latched one cycle after it appears.
- R7: In cycles where evt_done is low, dest_slot and dest_id do not change while the table is stable.
- R8: dest_slot and dest_id change at the clock edge that samples evt_done high. An edit to the table entry of the current slot appears on dest_id at the next clock edge, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_lo | input | 32 | Destination table entries 0 to 7, one nibble each, entry 0 in the low nibble |
| tbl_hi | input | 32 | Destination table entries 8 to 15, one nibble each, entry 8 in the low nibble |
| run_len | input | 32 | Events per destination; 0 fixes the destination to entry 0 |
| evt_done | input | 1 | One-cycle strobe per completed event |
| dest_id | output | 4 | Registered destination ID of the current slot |
| dest_slot | output | 4 | Registered index of the current table slot |

## Verification
If the event counter holds a wrong value, the first visible sign is a slot change one event early or one event late, so the scoreboard compares the slot and ID after every single event. A stale latched run length shows up only at the boundary that follows a run_len edit, and the stimulus places edits in the middle of runs for that reason. A pointer that fails to wrap, or an error in the nibble selection, appears within one pass of sixteen switch points. The bench therefore walks the pointer through the full table more than once. A table edit is checked on both sides of the output register to catch a selection made from the wrong cycle.

// File: rtl/evt_dest_pkg.sv
package evt_dest_pkg;

  // Action requested by the run counter from the slot pointer
  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_COUNT   = 2'd1,
    ACT_ADVANCE = 2'd2,
    ACT_REWIND  = 2'd3
  } slot_act_e;

endpackage

// File: rtl/dest_lut_mux.sv
module dest_lut_mux #(
  parameter int NUM_SLOTS = 16,
  parameter int ID_W      = 4,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int TBL_W    = NUM_SLOTS * ID_W
) (
  input  logic [TBL_W-1:0]  tbl_flat,
  input  logic [SLOT_W-1:0] sel,
  output logic [ID_W-1:0]   id_out
);

  logic [ID_W-1:0] entry [NUM_SLOTS];

  // Unpack one field per slot, lowest field first
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_unpack
    assign entry[k] = tbl_flat[k*ID_W +: ID_W];
  end

  assign id_out = entry[sel];

endmodule

// File: rtl/evt_run_counter.sv
module evt_run_counter
  import evt_dest_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic [CNT_W-1:0] cfg_len,
  output slot_act_e        act
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             zero_mode;
  logic             run_last;

  assign zero_mode = (lim_q == '0);
  assign run_last  = (cnt_q == lim_q - CNT_W'(1));

  always_comb begin
    if (zero_mode)
      act = ACT_REWIND;
    else if (evt && run_last)
      act = (cfg_len == '0) ? ACT_REWIND : ACT_ADVANCE;
    else if (evt)
      act = ACT_COUNT;
    else
      act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (zero_mode) begin
      cnt_q <= '0;
      lim_q <= cfg_len;
    end else if (evt && run_last) begin
      cnt_q <= '0;
      lim_q <= cfg_len;
    end else if (evt) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R3: the counter never reaches the latched limit
  a_r3_cnt_below_limit: assert property (@(posedge clk) disable iff (rst)
    !zero_mode |-> cnt_q < lim_q);

  // R6: the limit is reloaded only at a switch point or in zero mode
  a_r6_limit_held: assert property (@(posedge clk) disable iff (rst)
    (!zero_mode && !(evt && run_last)) |=> $stable(lim_q));

  // R5: zero mode keeps the pointer at the first entry
  a_r5_zero_rewinds: assert property (@(posedge clk) disable iff (rst)
    zero_mode |-> act == ACT_REWIND);

endmodule

// File: rtl/rr_slot_pointer.sv
module rr_slot_pointer
  import evt_dest_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  slot_act_e         act,
  output logic [SLOT_W-1:0] slot_d,
  output logic [SLOT_W-1:0] slot_q
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  always_comb begin
    unique case (act)
      ACT_REWIND:  slot_d = '0;
      ACT_ADVANCE: slot_d = (slot_q == LAST) ? '0 : slot_q + SLOT_W'(1);
      default:     slot_d = slot_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else     slot_q <= slot_d;
  end

  // R4: an advance steps by one, wrapping after the last slot
  a_r4_step_wrap: assert property (@(posedge clk) disable iff (rst)
    act == ACT_ADVANCE |=>
      slot_q == (($past(slot_q) == LAST) ? '0 : $past(slot_q) + SLOT_W'(1)));

  // R7: hold and count leave the pointer alone
  a_r7_no_move: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_HOLD || act == ACT_COUNT) |=> $stable(slot_q));

  // R5: a rewind lands on slot 0
  a_r5_rewind_zero: assert property (@(posedge clk) disable iff (rst)
    act == ACT_REWIND |=> slot_q == '0);

endmodule

// File: rtl/evt_dest_rotator.sv
module evt_dest_rotator
  import evt_dest_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int ID_W      = 4,
  parameter int REG_W     = 32,
  parameter int CNT_W     = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int TBL_W    = NUM_SLOTS * ID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  tbl_lo,
  input  logic [REG_W-1:0]  tbl_hi,
  input  logic [CNT_W-1:0]  run_len,
  input  logic              evt_done,
  output logic [ID_W-1:0]   dest_id,
  output logic [SLOT_W-1:0] dest_slot
);

  slot_act_e         act;
  logic [SLOT_W-1:0] slot_d;
  logic [SLOT_W-1:0] slot_q;
  logic [ID_W-1:0]   id_next;
  logic [TBL_W-1:0]  tbl_flat;
  logic [ID_W-1:0]   id_q;

  assign tbl_flat = TBL_W'({tbl_hi, tbl_lo});

  evt_run_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt_done),
    .cfg_len (run_len),
    .act     (act)
  );

  rr_slot_pointer #(.NUM_SLOTS(NUM_SLOTS)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .act    (act),
    .slot_d (slot_d),
    .slot_q (slot_q)
  );

  dest_lut_mux #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_lut (
    .tbl_flat (tbl_flat),
    .sel      (slot_d),
    .id_out   (id_next)
  );

  // Registered ID, looked up from the slot taken at this edge
  always_ff @(posedge clk) begin
    if (rst) id_q <= '0;
    else     id_q <= id_next;
  end

  assign dest_id   = id_q;
  assign dest_slot = slot_q;

  // R1: reset returns the selection to slot 0
  a_r1_reset_slot0: assert property (@(posedge clk)
    rst |=> dest_slot == '0);

  // R7: with no event and a stable table, the output stays put
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!evt_done && $stable(tbl_flat) && !$past(rst)) |=> $stable(dest_id));

endmodule

// File: tb/tb_evt_dest_rotator.sv
module tb_evt_dest_rotator;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] tbl_lo, tbl_hi, run_len;
  logic        evt_done;
  logic [3:0]  dest_id, dest_slot;

  always #4 clk = ~clk;  // 125 MHz

  evt_dest_rotator dut (
    .clk(clk), .rst(rst), .tbl_lo(tbl_lo), .tbl_hi(tbl_hi),
    .run_len(run_len), .evt_done(evt_done),
    .dest_id(dest_id), .dest_slot(dest_slot)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  // Specification model
  int unsigned m_ptr, m_cnt, m_lim;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [3:0] id_of(int k);
    logic [63:0] t;
    t = {tbl_hi, tbl_lo};
    return t[k*4 +: 4];
  endfunction

  task automatic model_event();
    if (m_lim == 0) m_lim = run_len;
    if (m_lim == 0) begin
      m_ptr = 0; m_cnt = 0;
    end else if (m_cnt == m_lim - 1) begin
      m_cnt = 0;
      m_lim = run_len;
      m_ptr = (run_len == 0) ? 0 : (m_ptr + 1) % 16;
    end else begin
      m_cnt++;
    end
  endtask

  // Driver: one event, expected result queued for the monitor
  task automatic send(string tag);
    @(negedge clk);
    model_event();
    exp_q.push_back({4'(m_ptr), id_of(m_ptr)});
    tag_q.push_back(tag);
    evt_done = 1'b1;
    @(negedge clk);
    evt_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_ptr = 0; m_cnt = 0; m_lim = 0;
    repeat (2) @(negedge clk);
  endtask

  // Monitor
  always @(posedge clk) begin
    if (evt_done && !rst) begin
      logic [7:0] e;
      string      t;
      #2;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " slot"}, 32'(dest_slot), 32'(e[7:4]));
      chk({t, " id"},   32'(dest_id),   32'(e[3:0]));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] t;
    for (int k = 0; k < 16; k++) t[k*4 +: 4] = 4'((k * 7 + 3) % 16);
    tbl_lo = t[31:0]; tbl_hi = t[63:32];
    run_len = 32'd2; evt_done = 1'b0; rst = 1'b0;

    do_reset();
    // R1: reset state
    chk("R1 slot", 32'(dest_slot), 32'd0);
    chk("R1 id", 32'(dest_id), 32'(tbl_lo[3:0]));

    // R3 R4 R2: run length 2 across more than one full wrap
    for (int i = 0; i < 36; i++) send("R3_R4");
    // R2: entry 8 comes from the low nibble of tbl_hi
    for (int i = 0; i < 16; i++) begin
      send("R2");
      if (m_ptr == 8 && m_cnt == 0) begin
        @(negedge clk);
        chk("R2 entry8", 32'(dest_id), 32'(tbl_hi[3:0]));
      end
    end

    // R7: idle cycles leave the selection alone
    begin
      logic [3:0] s0, i0;
      @(negedge clk); s0 = dest_slot; i0 = dest_id;
      repeat (5) @(negedge clk);
      chk("R7 slot", 32'(dest_slot), 32'(s0));
      chk("R7 id", 32'(dest_id), 32'(i0));
    end

    // R6: change run length mid-run
    while (m_cnt != 1) send("R6 align");
    run_len = 32'd3;
    @(negedge clk);
    for (int i = 0; i < 10; i++) send("R6");

    // R5: zero run length latched at next switch point
    run_len = 32'd0;
    @(negedge clk);
    for (int i = 0; i < 6; i++) send("R5");
    chk("R5 slot", 32'(dest_slot), 32'd0);

    // R6: leaving zero mode
    run_len = 32'd1;
    @(negedge clk);
    for (int i = 0; i < 20; i++) send("R6 exit zero");

    // R8: table edit on current slot shows one edge later
    while (m_ptr > 7) send("R8 align");
    begin
      logic [3:0] oldv, newv;
      @(negedge clk);
      oldv = dest_id;
      newv = ~oldv;
      tbl_lo[m_ptr*4 +: 4] = newv;
      #1;
      chk("R8 before edge", 32'(dest_id), 32'(oldv));
      @(negedge clk);
      chk("R8 after edge", 32'(dest_id), 32'(newv));
    end
    for (int i = 0; i < 5; i++) send("R8 R2");

    // R1: reset in the middle of a run
    run_len = 32'd4;
    @(negedge clk);
    for (int i = 0; i < 7; i++) send("R3 pre-reset");
    do_reset();
    chk("R1 mid slot", 32'(dest_slot), 32'd0);
    chk("R1 mid id", 32'(dest_id), 32'(id_of(0)));
    for (int i = 0; i < 9; i++) send("R1 R3 post-reset");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule